// File: doc/BRIEF.md
# Multi-converter read sequencer

This block is the host side of a group of successive-approximation converters that share one convert strobe, one serial clock and one serial data return line, with one active-low select per converter. A single start request begins a frame. The block raises the convert strobe while every select is high, so that each converter enters its chip-select read mode. It then waits out the worst-case conversion time and reads the converters one after another. Each read lowers that converter's select, waits a setup interval, and clocks in a fixed-width word, most significant bit first.

Every bit is captured on a serial-clock falling edge from the value the converter still holds on the line. The serial clock idles low, and a parameterised divider of the system clock sets its period. When the last converter has been read, all words appear together on a wide parallel output with a one-cycle done strobe. The strobe is then lowered, and the sequencer observes an acquisition interval before it takes the next start. Start requests that arrive at any point other than idle are dropped.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset cnv_o is low, every bit of cs_n_o is high, sck_o is low, done_o is low and result_o is zero.
- R2: A start_i seen high in idle raises cnv_o in the next cycle. cnv_o stays high for exactly T_CONV + N_CONV*(T_SETUP + 2*BITS*SCK_HALF + 1) cycles and falls in the cycle in which done_o is high. A select is low only while cnv_o is high.
- R3: When cnv_o rises every select is high, and all selects stay high for exactly T_CONV cycles before the first one is lowered.
- R4: At most one select is low at any time. Selects are lowered in index order 0, 1, ... N_CONV-1, once each per frame.
- R5: sck_o is high only while some select is low. Within a read, successive sck_o falling edges are 2*SCK_HALF cycles apart.
- R6: Each select stays low for exactly T_SETUP + 2*BITS*SCK_HALF cycles, and exactly BITS falling edges of sck_o occur during it. The select rises with the last of them.
- R7: At each falling edge the bit present on sdo_i is captured. The first captured bit is the most significant. Converter i's word appears in result_o[i*BITS +: BITS].
- R8: done_o is a single-cycle pulse per frame. result_o changes only in a cycle in which done_o is high and otherwise holds the previous frame's words.
- R9: start_i is ignored from the cycle in which the frame begins until the sequencer returns to idle: one frame produces exactly one cnv_o rise.
- R10: With start_i held high, cnv_o stays low for exactly T_ACQ + 2 cycles between frames. A start_i pulse during the acquisition interval starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, sampled in idle only |
| sdo_i | input | 1 | Shared serial data return from the converters |
| cnv_o | output | 1 | Shared convert strobe |
| sck_o | output | 1 | Shared serial clock, idles low |
| cs_n_o | output | N_CONV | Active-low select per converter |
| result_o | output | N_CONV*BITS | All converter words, converter i in slice i |
| done_o | output | 1 | One-cycle pulse when result_o is refreshed |

## Verification
Several properties are checked on every cycle: only one select is ever low, no select is low without the convert strobe, every select is high when the strobe rises, the serial clock is quiet outside a read, done is a single pulse at which the strobe falls, and the result never moves outside done. Other behaviour needs a whole frame of stimulus. The bench shows the exact lengths of the conversion wait, of each select window and of the strobe, the count and spacing of falling edges, and the select order. It also shows bit-exact capture across walking-one, alternating and random words, and the rejection of starts mid-frame and during acquisition together with the idle gap.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CONV,
      ST_SEL,
      ST_SHIFT,
      ST_DESEL,
      ST_DONE,
      ST_ACQ
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   function automatic int unsigned idx_width(input int unsigned count);
      return (count < 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/adc_sck_div.sv
module adc_sck_div #(
   parameter int unsigned SCK_HALF = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic sck_o,
   output logic fall_o
);

   logic sck_q;
   logic tick;

   generate
      if (SCK_HALF == 1) begin : g_fast
         assign tick = 1'b1;
      end else begin : g_counted
         localparam int unsigned CW = adc_seq_pkg::cnt_width(SCK_HALF - 1);
         localparam logic [CW-1:0] HALF_LAST = CW'(SCK_HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (!run_i || cnt_q == HALF_LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = (cnt_q == HALF_LAST);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_q <= 1'b0;
      end else if (!run_i) begin
         sck_q <= 1'b0;
      end else if (tick) begin
         sck_q <= ~sck_q;
      end
   end

   assign sck_o  = sck_q;
   assign fall_o = run_i && sck_q && tick;

   // R5: the clock returns low once the read window closes
   p_sck_parks_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !sck_o);

endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
   parameter int unsigned BITS = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            clr_i,
   input  logic            en_i,
   input  logic            bit_i,
   output logic [BITS-1:0] word_next_o
);

   logic [BITS-1:0] word_q;

   assign word_next_o = {word_q[BITS-2:0], bit_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
      end else if (clr_i) begin
         word_q <= '0;
      end else if (en_i) begin
         word_q <= word_next_o;
      end
   end

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned N_CONV  = 2,
   parameter int unsigned BITS    = 16,
   parameter int unsigned T_CONV  = 40,
   parameter int unsigned T_SETUP = 2,
   parameter int unsigned T_ACQ   = 8,
   localparam int unsigned IW     = idx_width(N_CONV)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              fall_i,
   output logic              cnv_o,
   output logic [N_CONV-1:0] cs_n_o,
   output logic              run_o,
   output logic              clr_o,
   output logic              store_o,
   output logic              frame_end_o,
   output logic              done_o,
   output logic [IW-1:0]     idx_o
);

   localparam int unsigned T_MAX0 = (T_CONV > T_SETUP) ? T_CONV : T_SETUP;
   localparam int unsigned T_MAX  = (T_MAX0 > T_ACQ) ? T_MAX0 : T_ACQ;
   localparam int unsigned TW     = cnt_width(T_MAX);
   localparam int unsigned FW     = cnt_width(BITS - 1);

   localparam logic [TW-1:0] CONV_LAST  = TW'(T_CONV - 1);
   localparam logic [TW-1:0] SETUP_LAST = TW'(T_SETUP - 1);
   localparam logic [TW-1:0] ACQ_LAST   = TW'(T_ACQ - 1);
   localparam logic [FW-1:0] FALL_LAST  = FW'(BITS - 1);
   localparam logic [IW-1:0] IDX_LAST   = IW'(N_CONV - 1);

   seq_state_t    state_q;
   logic [TW-1:0] tcnt_q;
   logic [FW-1:0] fcnt_q;
   logic [IW-1:0] idx_q;
   logic          sel_phase;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         tcnt_q  <= '0;
         fcnt_q  <= '0;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               idx_q  <= '0;
               tcnt_q <= '0;
               if (start_i) begin
                  state_q <= ST_CONV;
               end
            end
            ST_CONV: begin
               if (tcnt_q == CONV_LAST) begin
                  tcnt_q  <= '0;
                  state_q <= ST_SEL;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            ST_SEL: begin
               if (tcnt_q == SETUP_LAST) begin
                  tcnt_q  <= '0;
                  fcnt_q  <= '0;
                  state_q <= ST_SHIFT;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (fall_i) begin
                  if (fcnt_q == FALL_LAST) begin
                     state_q <= ST_DESEL;
                  end else begin
                     fcnt_q <= fcnt_q + 1'b1;
                  end
               end
            end
            ST_DESEL: begin
               if (idx_q == IDX_LAST) begin
                  state_q <= ST_DONE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_SEL;
               end
            end
            ST_DONE: begin
               tcnt_q  <= '0;
               state_q <= ST_ACQ;
            end
            ST_ACQ: begin
               if (tcnt_q == ACQ_LAST) begin
                  tcnt_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  tcnt_q <= tcnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sel_phase = (state_q == ST_SEL) || (state_q == ST_SHIFT);

   generate
      for (genvar g = 0; g < N_CONV; g++) begin : g_sel
         assign cs_n_o[g] = !(sel_phase && (idx_q == IW'(g)));
      end
   endgenerate

   assign cnv_o       = (state_q == ST_CONV) || sel_phase || (state_q == ST_DESEL);
   assign run_o       = (state_q == ST_SHIFT);
   assign clr_o       = (state_q == ST_SEL);
   assign store_o     = run_o && fall_i && (fcnt_q == FALL_LAST);
   assign frame_end_o = (state_q == ST_DESEL) && (idx_q == IDX_LAST);
   assign done_o      = (state_q == ST_DONE);
   assign idx_o       = idx_q;

   // R4: never two converters driving the shared line
   p_single_select_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~cs_n_o));

   // R2: a select is only lowered under the convert strobe
   p_select_under_cnv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_n_o != '1) |-> cnv_o);

   // R3: every converter sees its select high as the strobe rises
   p_cnv_rise_selects_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cnv_o) |-> (cs_n_o == '1));

   // R2: the strobe drops only together with done
   p_cnv_falls_at_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cnv_o) |-> done_o);

   // R8: done lasts one cycle
   p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R9: no new frame can start outside idle
   p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> !$rose(cnv_o));

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader #(
   parameter int unsigned N_CONV   = 2,
   parameter int unsigned BITS     = 16,
   parameter int unsigned SCK_HALF = 2,
   parameter int unsigned T_CONV   = 40,
   parameter int unsigned T_SETUP  = 2,
   parameter int unsigned T_ACQ    = 8
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     start_i,
   input  logic                     sdo_i,
   output logic                     cnv_o,
   output logic                     sck_o,
   output logic [N_CONV-1:0]        cs_n_o,
   output logic [N_CONV*BITS-1:0]   result_o,
   output logic                     done_o
);

   localparam int unsigned IW = adc_seq_pkg::idx_width(N_CONV);
   localparam int unsigned RW = N_CONV * BITS;

   generate
      if (N_CONV < 1) begin : g_bad_count
         $error("N_CONV must be at least 1");
      end
      if (BITS < 2) begin : g_bad_bits
         $error("BITS must be at least 2");
      end
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
      if (T_CONV < 1 || T_SETUP < 1 || T_ACQ < 1) begin : g_bad_time
         $error("timing parameters must be at least 1");
      end
   endgenerate

   logic            run;
   logic            fall;
   logic            clr;
   logic            store;
   logic            frame_end;
   logic [IW-1:0]   idx;
   logic [BITS-1:0] word_next;
   logic [RW-1:0]   stage_flat;
   logic [RW-1:0]   result_q;

   adc_frame_ctrl #(
      .N_CONV  (N_CONV),
      .BITS    (BITS),
      .T_CONV  (T_CONV),
      .T_SETUP (T_SETUP),
      .T_ACQ   (T_ACQ)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .fall_i      (fall),
      .cnv_o       (cnv_o),
      .cs_n_o      (cs_n_o),
      .run_o       (run),
      .clr_o       (clr),
      .store_o     (store),
      .frame_end_o (frame_end),
      .done_o      (done_o),
      .idx_o       (idx)
   );

   adc_sck_div #(
      .SCK_HALF (SCK_HALF)
   ) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .sck_o  (sck_o),
      .fall_o (fall)
   );

   adc_shift_rx #(
      .BITS (BITS)
   ) u_rx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr),
      .en_i        (fall),
      .bit_i       (sdo_i),
      .word_next_o (word_next)
   );

   generate
      for (genvar g = 0; g < N_CONV; g++) begin : g_stage
         logic [BITS-1:0] stage_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stage_q <= '0;
            end else if (store && (idx == IW'(g))) begin
               stage_q <= word_next;
            end
         end

         assign stage_flat[g*BITS +: BITS] = stage_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         result_q <= '0;
      end else if (frame_end) begin
         result_q <= stage_flat;
      end
   end

   assign result_o = result_q;

   // R5: serial clock activity only inside a read window
   p_sck_needs_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sck_o |-> (cs_n_o != '1));

   // R8: the parallel result moves only with done
   p_result_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));

   // R6: the select of the current read stays low while the clock runs
   p_select_holds_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sck_o && !$past(sck_o)) |-> $stable(cs_n_o));

endmodule

// File: tb/test_adc_chain_reader.sv
`timescale 1ns/1ps
module test_adc_chain_reader;

   localparam int N     = 3;
   localparam int BITS  = 16;
   localparam int HALF  = 2;
   localparam int TCONV = 24;
   localparam int TSET  = 2;
   localparam int TACQ  = 6;
   localparam real PERIOD = 8.0;

   localparam int CS_LEN  = TSET + 2 * BITS * HALF;
   localparam int CNV_LEN = TCONV + N * (CS_LEN + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              sdo = 1'bz;
   logic              cnv, sck, done;
   logic [N-1:0]      cs_n;
   logic [N*BITS-1:0] result;

   logic [BITS-1:0] words [N];
   logic [BITS-1:0] exp_w [N];
   logic [BITS-1:0] prev_w [N];
   bit              have_prev = 0;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   always #(PERIOD / 2.0) clk = ~clk;

   adc_chain_reader #(
      .N_CONV (N), .BITS (BITS), .SCK_HALF (HALF),
      .T_CONV (TCONV), .T_SETUP (TSET), .T_ACQ (TACQ)
   ) i_adc_chain_reader (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start), .sdo_i (sdo),
      .cnv_o (cnv), .sck_o (sck), .cs_n_o (cs_n), .result_o (result),
      .done_o (done)
   );

   // converter model: MSB on select fall, next bit after each clock fall
   initial begin : conv_model
      logic [N-1:0] pcs;
      logic         psck;
      int           act;
      int           ptr;
      pcs = '1; psck = 1'b0; act = -1; ptr = -1;
      forever begin
         @(cs_n or sck);
         #1;
         for (int i = 0; i < N; i++) begin
            if (pcs[i] && !cs_n[i]) begin
               act = i;
               ptr = BITS - 1;
            end
         end
         if (psck && !sck && act >= 0) ptr--;
         if (act >= 0 && cs_n[act]) act = -1;
         pcs  = cs_n;
         psck = sck;
         sdo  = (act >= 0 && ptr >= 0) ? words[act][ptr] : 1'bz;
      end
   end

   // monitor: samples pre-edge values
   int cyc = 0, rises = 0, cnv_len = 0, last_cnv_len = 0, wait_len = 0;
   int gap_cnt = 0, gap_last = 0, npos = 0, last_fall = 0, prev_act = -1;
   int bad_sck = 0, bad_multi = 0, bad_period = 0;
   int cs_len [N];
   int falls [N];
   int order [N];
   bit seen_sel = 0;
   logic prev_cnv = 1'b0, prev_sck = 1'b0;
   logic [N-1:0] prev_cs = '1;

   always @(posedge clk) begin : mon
      int act;
      if (rst_n) begin
         cyc++;
         if (cnv && !prev_cnv) begin
            rises++;
            gap_last = gap_cnt;
            cnv_len = 0; wait_len = 0; npos = 0; seen_sel = 0;
            for (int i = 0; i < N; i++) begin
               cs_len[i] = 0; falls[i] = 0; order[i] = -1;
            end
         end
         if (!cnv && prev_cnv) begin
            last_cnv_len = cnv_len;
            gap_cnt = 0;
         end
         if (cnv) cnv_len++;
         else gap_cnt++;
         if (cnv && (&cs_n) && !seen_sel) wait_len++;
         if ($countones(~cs_n) > 1) bad_multi++;
         act = -1;
         for (int i = 0; i < N; i++) if (!cs_n[i]) act = i;
         if (prev_sck && !sck && prev_act >= 0) begin
            if (falls[prev_act] > 0 && (cyc - last_fall) != 2 * HALF) bad_period++;
            falls[prev_act]++;
            last_fall = cyc;
         end
         if (act >= 0) begin
            if (prev_cs[act]) begin
               if (npos < N) order[npos] = act;
               npos++;
               seen_sel = 1;
            end
            cs_len[act]++;
         end else if (sck) begin
            bad_sck++;
         end
         prev_cnv = cnv; prev_sck = sck; prev_cs = cs_n; prev_act = act;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_done();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!done && n < 5000);
      chk("R8 done reached", done, 1);
   endtask

   task automatic run_frame(input bit mid_start);
      int r0;
      for (int i = 0; i < N; i++) exp_w[i] = words[i];
      r0 = rises;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (mid_start || have_prev) begin
         repeat (100) @(negedge clk);
         if (mid_start) start = 1'b1;
         if (have_prev) begin
            for (int i = 0; i < N; i++)
               chk("R8 result held mid-frame", result[i*BITS +: BITS], prev_w[i]);
         end
         @(negedge clk);
         start = 1'b0;
      end
      wait_done();
      for (int i = 0; i < N; i++)
         chk("R7 captured word", result[i*BITS +: BITS], exp_w[i]);
      chk("R2 cnv low at done", cnv, 0);
      @(negedge clk);
      chk("R8 done single pulse", done, 0);
      @(negedge clk);
      chk("R2 cnv high length", last_cnv_len, CNV_LEN);
      chk("R3 conversion wait", wait_len, TCONV);
      chk("R9 one cnv rise", rises - r0, 1);
      chk("R4 selects per frame", npos, N);
      for (int i = 0; i < N; i++) begin
         chk("R4 select order", order[i], i);
         chk("R6 select low length", cs_len[i], CS_LEN);
         chk("R6 falls per select", falls[i], BITS);
      end
      chk("R4 multiple selects", bad_multi, 0);
      chk("R5 sck outside select", bad_sck, 0);
      chk("R5 fall spacing", bad_period, 0);
      for (int i = 0; i < N; i++) prev_w[i] = exp_w[i];
      have_prev = 1;
      repeat (TACQ) @(negedge clk);
   endtask

   initial begin : watchdog
      #(PERIOD * 200000);
      if (!finished) begin
         finished = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      int r0;
      for (int i = 0; i < N; i++) words[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 cnv", cnv, 0);
      chk("R1 cs_n", cs_n, {N{1'b1}});
      chk("R1 sck", sck, 0);
      chk("R1 done", done, 0);
      chk("R1 result", result, 0);

      // fixed patterns
      for (int i = 0; i < N; i++) words[i] = '0;
      run_frame(0);
      for (int i = 0; i < N; i++) words[i] = '1;
      run_frame(1);
      for (int i = 0; i < N; i++) words[i] = (i % 2) ? 16'h5555 : 16'hAAAA;
      run_frame(0);
      for (int i = 0; i < N; i++) words[i] = 16'h8001 ^ BITS'(i * 16'h1111);
      run_frame(1);

      // walking one across every bit position
      for (int k = 0; k < BITS; k++) begin
         for (int i = 0; i < N; i++) words[i] = BITS'(1) << ((k + i) % BITS);
         run_frame(k % 3 == 0);
      end

      // random words
      for (int k = 0; k < 6; k++) begin
         for (int i = 0; i < N; i++) words[i] = BITS'($urandom);
         run_frame(k % 2 == 1);
      end

      // R10: start held high across two frames, gap measured
      for (int i = 0; i < N; i++) words[i] = BITS'($urandom);
      for (int i = 0; i < N; i++) exp_w[i] = words[i];
      start = 1'b1;
      wait_done();
      @(negedge clk);
      wait_done();
      start = 1'b0;
      chk("R10 held start gap", gap_last, TACQ + 2);
      for (int i = 0; i < N; i++)
         chk("R7 word with held start", result[i*BITS +: BITS], exp_w[i]);

      // R10: pulse during acquisition is dropped
      repeat (2) @(negedge clk);
      r0 = rises;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (TACQ + 4) @(negedge clk);
      chk("R10 acq start ignored", rises - r0, 0);
      chk("R10 cnv stays low", cnv, 0);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule